// File: doc/BRIEF.md
# Delay-Line Calibration and Sampling-Phase Tuner

This block sets up a programmable receive delay line for a high-speed SD host in two stages. In the first stage it looks for a unit-delay code. It steps the code upward from zero and, for each code, waits for the line to report a measured length pattern. It keeps the first code whose pattern is nonzero and shorter than one clock period. The highest set bit of that pattern gives the last usable phase. Each code has a programmable cycle timeout, so a silent line cannot stall the search.

In the second stage the block steps the phase select from zero up to that last usable phase. For each phase it raises a request to an external tuning check and waits for a pass or fail answer. It tracks the longest unbroken run of passing phases. When the sweep ends, it bypasses the line for one cycle and then programs the middle of the best run. A one-cycle done pulse ends the job, and an error flag goes with it when either stage finds nothing usable.

Top module: `dly_tuner`

## Requirements
- R1: While reset is held and after it is released, done_o, err_o, dly_en_o, smp_en_o and chk_req_o are low, and phase_o and unit_o are zero.
- R2: After start_i is sampled in idle, unit_o starts at 0. While the unit search runs, dly_en_o and smp_en_o are both high and phase_o is 12.
- R3: A unit code is accepted when len_vld_i is high and len_i is nonzero and below 2^11. A valid len_i outside that range moves the search to the next code. The accepted code stays on unit_o.
- R4: If len_vld_i stays low for timeout_i+1 cycles on one code, the search moves to the next code. With no response at all, the 128-code search ends in an error done pulse 128*(timeout_i+1) cycles after the start cycle.
- R5: The sweep visits phases 0 up to the index of the highest set bit of the accepted len_i, inclusive, with exactly one check request per phase. Higher phases are never requested.
- R6: The chosen window is the longest run of consecutive passing phases. When two runs have the same length, the earlier one is kept.
- R7: The final phase_o equals the last phase of the chosen run minus half the run length, rounded down. It is programmed with dly_en_o high, smp_en_o low and unit_o holding the accepted code.
- R8: In the cycle just before a successful done pulse, dly_en_o and smp_en_o are both low, so the line is bypassed.
- R9: While chk_req_o is high, dly_en_o is high, smp_en_o is low and phase_o is stable. chk_req_o stays high until chk_done_i, and chk_pass_i is sampled in that same cycle.
- R10: done_o is a one-cycle pulse, and err_o is high only together with it. An error is reported when no code is accepted or when no phase passes. With an error, dly_en_o and smp_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a calibration (sampled in idle) |
| timeout_i | input | 16 | Cycles to wait for len_vld_i per unit code |
| len_i | input | 12 | Measured length pattern from the line |
| len_vld_i | input | 1 | len_i is valid for the current code |
| chk_done_i | input | 1 | Tuning check finished |
| chk_pass_i | input | 1 | Tuning check result, 1 = pass |
| chk_req_o | output | 1 | Tuning check request for the current phase |
| dly_en_o | output | 1 | Delay line enable |
| smp_en_o | output | 1 | Length sampler enable |
| phase_o | output | 4 | Phase select |
| unit_o | output | 7 | Unit delay code |
| done_o | output | 1 | Job finished (one-cycle pulse) |
| err_o | output | 1 | Job failed (valid with done_o) |

## Verification
The assertions assume that len_vld_i refers to the unit code now on unit_o, that chk_done_i arrives only while a request is pending, and that start_i is raised only while the block is idle. The bench meets these assumptions with response models that watch the outputs at the falling edge. The length model drops its valid flag as soon as the code changes and raises it again only after a fixed settling delay, or never for a code marked silent. The check model answers each request once, after a fixed latency, and does not answer again until the request has fallen and risen.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CAL, S_SET, S_REQ, S_EVAL, S_BYP
  } state_e;
endpackage

// File: rtl/dlt_len_cal.sv
module dlt_len_cal #(
  parameter int UNIT_W = 7,
  parameter int LEN_W  = 12,
  parameter int N_TAPS = 11,
  parameter int PH_W   = 4,
  parameter int TO_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              act_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              len_vld_i,
  output logic [UNIT_W-1:0] unit_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic [PH_W-1:0]   max_ph_o
);
  localparam logic [UNIT_W-1:0] UNIT_MAX = '1;

  logic [UNIT_W-1:0] unit_q;
  logic [TO_W-1:0]   cnt_q;
  logic              len_ok, timed_out, adv;

  assign len_ok    = len_vld_i && (len_i != '0) && ((len_i >> N_TAPS) == '0);
  assign timed_out = !len_vld_i && (cnt_q >= timeout_i);
  assign adv       = act_i && ((len_vld_i && !len_ok) || timed_out);
  assign hit_o     = act_i && len_ok;
  assign miss_o    = adv && (unit_q == UNIT_MAX);
  assign unit_o    = unit_q;

  always_comb begin
    max_ph_o = '0;
    for (int i = 0; i < LEN_W; i++)
      if (len_i[i]) max_ph_o = PH_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      unit_q <= '0;
      cnt_q  <= '0;
    end else if (adv) begin
      if (unit_q != UNIT_MAX) unit_q <= unit_q + 1'b1;
      cnt_q <= '0;
    end else if (act_i && cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // accepted length always yields a phase inside the tap range
  assert_maxph_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (max_ph_o < PH_W'(N_TAPS)));
endmodule

// File: rtl/dlt_win_track.sv
module dlt_win_track #(
  parameter int PH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            upd_i,
  input  logic            pass_i,
  input  logic [PH_W-1:0] ph_i,
  output logic [PH_W:0]   best_o,
  output logic [PH_W-1:0] centre_o
);
  logic [PH_W:0]   cur_q, best_q, cur_nx;
  logic [PH_W-1:0] end_q;

  assign cur_nx   = cur_q + 1'b1;
  assign best_o   = best_q;
  assign centre_o = end_q - PH_W'(best_q >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (clr_i) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (upd_i) begin
      if (pass_i) begin
        cur_q <= cur_nx;
        if (cur_nx > best_q) begin
          best_q <= cur_nx;
          end_q  <= ph_i;
        end
      end else begin
        cur_q <= '0;
      end
    end
  end

  assert_run_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q <= best_q);
endmodule

// File: rtl/dly_tuner.sv
module dly_tuner #(
  parameter int UNIT_W = 7,
  parameter int LEN_W  = 12,
  parameter int N_TAPS = 11,
  parameter int PH_W   = 4,
  parameter int CAL_PH = 12,
  parameter int TO_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              len_vld_i,
  input  logic              chk_done_i,
  input  logic              chk_pass_i,
  output logic              chk_req_o,
  output logic              dly_en_o,
  output logic              smp_en_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic              done_o,
  output logic              err_o
);
  import dlt_pkg::*;

  localparam logic [PH_W-1:0] CAL_SEL = PH_W'(CAL_PH);

  state_e          state_q;
  logic [PH_W-1:0] ph_q, max_ph_q, phase_q;
  logic            dly_en_q, smp_en_q, done_q, err_q;

  logic            clr, hit, miss, upd;
  logic [PH_W-1:0] max_ph, centre;
  logic [PH_W:0]   best;

  assign clr = (state_q == S_IDLE) && start_i;
  assign upd = (state_q == S_REQ) && chk_done_i;

  dlt_len_cal #(
    .UNIT_W(UNIT_W), .LEN_W(LEN_W), .N_TAPS(N_TAPS), .PH_W(PH_W), .TO_W(TO_W)
  ) i_len_cal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .act_i    (state_q == S_CAL),
    .timeout_i(timeout_i),
    .len_i    (len_i),
    .len_vld_i(len_vld_i),
    .unit_o   (unit_o),
    .hit_o    (hit),
    .miss_o   (miss),
    .max_ph_o (max_ph)
  );

  dlt_win_track #(.PH_W(PH_W)) i_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .upd_i   (upd),
    .pass_i  (chk_pass_i),
    .ph_i    (ph_q),
    .best_o  (best),
    .centre_o(centre)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      ph_q     <= '0;
      max_ph_q <= '0;
      phase_q  <= '0;
      dly_en_q <= 1'b0;
      smp_en_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          dly_en_q <= 1'b1;
          smp_en_q <= 1'b1;
          phase_q  <= CAL_SEL;
          state_q  <= S_CAL;
        end
        S_CAL: if (hit) begin
          max_ph_q <= max_ph;
          ph_q     <= '0;
          smp_en_q <= 1'b0;
          state_q  <= S_SET;
        end else if (miss) begin
          dly_en_q <= 1'b0;
          smp_en_q <= 1'b0;
          phase_q  <= '0;
          done_q   <= 1'b1;
          err_q    <= 1'b1;
          state_q  <= S_IDLE;
        end
        S_SET: begin
          phase_q <= ph_q;
          state_q <= S_REQ;
        end
        S_REQ: if (chk_done_i) begin
          if (ph_q == max_ph_q) begin
            state_q <= S_EVAL;
          end else begin
            ph_q    <= ph_q + 1'b1;
            state_q <= S_SET;
          end
        end
        S_EVAL: begin
          dly_en_q <= 1'b0;
          if (best == '0) begin
            phase_q <= '0;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_BYP;
          end
        end
        S_BYP: begin
          phase_q  <= centre;
          dly_en_q <= 1'b1;
          done_q   <= 1'b1;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign chk_req_o = (state_q == S_REQ);
  assign dly_en_o  = dly_en_q;
  assign smp_en_o  = smp_en_q;
  assign phase_o   = phase_q;
  assign done_o    = done_q;
  assign err_o     = done_q & err_q;

  assert_cal_cfg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CAL) |-> (dly_en_o && smp_en_o && phase_o == CAL_SEL));
  assert_sweep_cfg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_req_o |-> (dly_en_o && !smp_en_o && phase_o <= max_ph_q));
  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_req_o && !chk_done_i) |=> (chk_req_o && $stable(phase_o)));
  assert_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> ($past(!dly_en_o && !smp_en_o) && dly_en_o));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!dly_en_o && !smp_en_o));
endmodule

// File: tb/test_dly_tuner.sv
module test_dly_tuner;
  localparam int LEN_LAT = 2;
  localparam int CHK_LAT = 3;
  localparam int LIMIT   = 20000;

  typedef struct packed {
    logic [7:0]  acc;
    logic [11:0] bad;
    logic [11:0] lenv;
    logic [7:0]  sil;
    logic [15:0] pat;
    logic [7:0]  tmo;
    logic        xerr;
    logic [6:0]  xunit;
    logic [3:0]  xph;
    logic [4:0]  nreq;
  } vec_t;

  // acc, bad len, accepted len, silent unit, pass pattern, timeout, err, unit, phase, requests
  localparam vec_t TAB [8] = '{
    '{8'd3, 12'h000, 12'h0F0, 8'd200, 16'h001C, 8'd8, 1'b0, 7'd3, 4'd3,  5'd8},
    '{8'd5, 12'h800, 12'h400, 8'd200, 16'h03E3, 8'd8, 1'b0, 7'd5, 4'd7,  5'd11},
    '{8'd0, 12'h000, 12'h001, 8'd200, 16'h0001, 8'd8, 1'b0, 7'd0, 4'd0,  5'd1},
    '{8'd1, 12'h000, 12'h00C, 8'd200, 16'h0000, 8'd8, 1'b1, 7'd1, 4'd0,  5'd4},
    '{8'd2, 12'h000, 12'h0FF, 8'd200, 16'h0033, 8'd8, 1'b0, 7'd2, 4'd0,  5'd8},
    '{8'd1, 12'h000, 12'h040, 8'd200, 16'h0378, 8'd8, 1'b0, 7'd1, 4'd4,  5'd7},
    '{8'd4, 12'h000, 12'h020, 8'd2,   16'h003F, 8'd8, 1'b0, 7'd4, 4'd2,  5'd6},
    '{8'd2, 12'hFFF, 12'h7FF, 8'd200, 16'h0400, 8'd8, 1'b0, 7'd2, 4'd10, 5'd11}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] timeout = 16'd8;
  logic [11:0] len = '0;
  logic        len_vld = 1'b0;
  logic        chk_done = 1'b0;
  logic        chk_pass = 1'b0;
  logic        chk_req, dly_en, smp_en, done, err;
  logic [3:0]  phase;
  logic [6:0]  unit;

  logic [7:0]  g_acc = 8'd200, g_sil = 8'd200;
  logic [11:0] g_bad = '0, g_lenv = '0;
  logic [15:0] g_pat = '0;
  int          n_req = 0;
  int          errors = 0, checks = 0;
  int          cyc;
  logic        prev_dly;

  always #2.5 clk = ~clk;

  dly_tuner i_dly_tuner (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .timeout_i(timeout),
    .len_i(len), .len_vld_i(len_vld), .chk_done_i(chk_done), .chk_pass_i(chk_pass),
    .chk_req_o(chk_req), .dly_en_o(dly_en), .smp_en_o(smp_en), .phase_o(phase),
    .unit_o(unit), .done_o(done), .err_o(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // length sense model: valid after LEN_LAT stable cycles, never on the silent code
  initial begin : len_model
    logic [6:0] last_u;
    int age;
    logic act;
    last_u = '0; age = 0; act = 1'b0;
    forever begin
      @(negedge clk);
      if (dly_en && smp_en) begin
        if (!act || unit != last_u) begin
          act = 1'b1; last_u = unit; age = 0; len_vld = 1'b0;
        end else age++;
        if (age >= LEN_LAT && {1'b0, unit} != g_sil) begin
          len_vld = 1'b1;
          len = ({1'b0, unit} == g_acc) ? g_lenv : g_bad;
        end
      end else begin
        act = 1'b0; len_vld = 1'b0;
      end
    end
  end

  // tuning check model
  initial begin : chk_model
    forever begin
      @(negedge clk);
      if (chk_req) begin
        n_req++;
        repeat (CHK_LAT) @(negedge clk);
        chk_pass = g_pat[phase];
        chk_done = 1'b1;
        @(negedge clk);
        chk_done = 1'b0;
        chk_pass = 1'b0;
      end
    end
  end

  task automatic run_job;
    n_req = 0;
    cyc = 0;
    prev_dly = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (!done && cyc < LIMIT) begin
      prev_dly = dly_en;
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R10: actual=no_done expected=done");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 dly_en", dly_en, 0);
    chk("R1 phase", phase, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 smp_en", smp_en, 0);
    chk("R1 chk_req", chk_req, 0);
    chk("R1 unit", unit, 0);
    chk("R1 err", err, 0);

    for (int v = 0; v < 8; v++) begin
      g_acc = TAB[v].acc; g_bad = TAB[v].bad; g_lenv = TAB[v].lenv;
      g_sil = TAB[v].sil; g_pat = TAB[v].pat; timeout = 16'(TAB[v].tmo);
      run_job();
      chk($sformatf("R10 err v%0d", v), err, TAB[v].xerr);
      chk($sformatf("R5 requests v%0d", v), n_req, TAB[v].nreq);
      if (TAB[v].xerr) begin
        chk($sformatf("R10 dly_en off v%0d", v), dly_en, 0);
        chk($sformatf("R10 smp_en off v%0d", v), smp_en, 0);
      end else begin
        chk($sformatf("R3 unit v%0d", v), unit, TAB[v].xunit);
        chk($sformatf("R7 phase v%0d (R6 window)", v), phase, TAB[v].xph);
        chk($sformatf("R7 dly_en v%0d", v), dly_en, 1);
        chk($sformatf("R9 smp_en v%0d", v), smp_en, 0);
        chk($sformatf("R8 bypass v%0d", v), prev_dly, 0);
      end
      @(negedge clk);
      chk($sformatf("R10 pulse v%0d", v), done, 0);
      repeat (2) @(negedge clk);
    end

    // every code rejected by a zero length
    g_acc = 8'd200; g_bad = 12'h000; g_sil = 8'd200; timeout = 16'd8;
    run_job();
    chk("R3 all rejected err", err, 1);
    chk("R10 no config dly_en", dly_en, 0);
    chk("R2 search reached last code", unit, 127);

    // every code silent: pure timeout walk
    g_sil = 8'd0; timeout = 16'd3;
    for (int u = 0; u < 1; u++) g_sil = 8'd255;
    g_acc = 8'd200;
    begin : silent_all
      logic [7:0] s;
      s = 8'd0;
      g_sil = s;
    end
    // silent for every code: force silence via acceptance on no code and valid never raised
    g_sil = 8'd200;
    timeout = 16'd3;
    force len_vld = 1'b0;
    run_job();
    release len_vld;
    chk("R4 timeout err", err, 1);
    chk("R4 timeout cycles", cyc, 128 * 4 + 1);

    // a length with bits above the period is skipped even when later codes are good
    g_acc = 8'd1; g_bad = 12'hC00; g_lenv = 12'h004; g_pat = 16'h0007; timeout = 16'd8;
    run_job();
    chk("R3 skip long length unit", unit, 1);
    chk("R7 phase small window", phase, 1);
    chk("R5 requests small window", n_req, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule